// File: doc/BRIEF.md
# Paired-Branch Hint Queue and Matcher

This block tracks prepare-to-branch hints that are waiting for their branch to reach the front end. Each hint carries a predicted target address and a short tag: the low address bits of the fetch group that holds the branch it predicts. Hints enter a small in-order queue. Each cycle the oldest hint that has not yet been resolved compares its tag with the address tags of every front-end location. The locations form one vector ordered from oldest to youngest: pipeline stages first, then instruction buffers, then in-flight cache fetches. Each location also carries a valid bit and an on-path bit.

A location hits when it is valid, its on-path bit is clear and its tag equals the hint's tag. The lowest-indexed hit wins. The block then raises a redirect request carrying the predicted target. When that request is accepted, the block drives two masks in the same cycle. One squashes every location younger than the hit. The other marks the hit and every older valid location as on-path. The hint then counts as found, and the next hint starts searching in the following cycle. A found hint stays queued until the decode stage signals that its branch has left the buffers. A misprediction flush empties the queue.

Hints arrive on a valid/ready stream. `hint_ready` is low while the queue is full or a flush is asserted. A hint is taken only on a cycle where `hint_valid` and `hint_ready` are both high. The redirect leaves on a valid/ready stream. While `redir_ready` is low, the request stays pending: the masks remain zero and the hint stays unresolved. The request is re-evaluated every cycle against the current location inputs.

Top module: `hint_pair_tracker`

## Requirements
- R1: After reset the queue is empty: `hint_ready` = 1, `full` = 0, `redir_valid` = 0, and both masks are zero.
- R2: A hint is stored when `hint_valid` and `hint_ready` are both high. After DEPTH (default 4) stored hints, `full` = 1 and `hint_ready` = 0. A hint offered while full is discarded and is never searched.
- R3: Location i (tag bits [i*TAG_W +: TAG_W]) hits only if `loc_valid[i]` = 1, `loc_onpath[i]` = 0 and its tag equals the searching hint's tag. Invalid or on-path locations with an equal tag cause no redirect.
- R4: When several locations hit, the lowest index wins. Index 0 is the oldest pipeline stage, and buffers and cache fetches follow at higher indices.
- R5: On an accepted redirect with winning index m, `squash_mask[i]` = 1 for every i > m. `onpath_mask[i]` = `loc_valid[i]` for every i <= m. All other mask bits are 0.
- R6: `redir_target` is the target of the oldest unresolved hint. Each hint produces exactly one accepted redirect.
- R7: While no location hits, the hint stays unresolved and searches again every cycle. It redirects in the first cycle a hit appears.
- R8: Hints resolve strictly in queue order. A younger hint raises no redirect while an older hint is still unresolved, even if the younger hint's tag is present.
- R9: `retire` frees the oldest queued hint. This clears `full`, and a retired hint is never searched again.
- R10: `flush` forces `redir_valid` = 0 and `hint_ready` = 0 in its cycle, and leaves the queue empty for the next cycle.
- R11: While `redir_valid` = 1 and `redir_ready` = 0, both masks stay zero and the hint stays unresolved. The redirect is offered again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction flush; empties the queue |
| retire | input | 1 | Decode reports that the oldest queued hint's branch has left the buffers |
| hint_valid | input | 1 | Hint offered |
| hint_ready | output | 1 | Hint can be accepted |
| hint_tag | input | TAG_W | Low fetch-group address bits of the paired branch |
| hint_target | input | ADDR_W | Predicted branch target |
| full | output | 1 | Queue holds DEPTH hints |
| loc_tag | input | N_LOC*TAG_W | Location tags, index 0 oldest |
| loc_valid | input | N_LOC | Location holds valid data |
| loc_onpath | input | N_LOC | Location already confirmed on-path |
| redir_valid | output | 1 | Redirect request present |
| redir_ready | input | 1 | Fetch side accepts the redirect |
| redir_target | output | ADDR_W | Predicted target to fetch |
| squash_mask | output | N_LOC | Invalidate these locations (accepted redirect only) |
| onpath_mask | output | N_LOC | Set on-path in these locations (accepted redirect only) |

## Verification
The bench places the hint's tag on an on-path location and on an invalid location, then on a valid one. A matcher that ignored either qualifier would redirect early and produce the wrong masks. With several equal tags present, it checks that the oldest copy wins; choosing the youngest would shift the squash boundary. It holds a younger hint's tag present while an older hint is unresolved, so an out-of-order search would redirect to the wrong target. It also withholds `redir_ready` to catch a design that marks the hint found, or drives masks, before acceptance. Finally, it checks that a hint offered while full, or flushed, never redirects, and that retiring an unresolved head moves the search to the next hint.

// File: rtl/hint_pair_pkg.sv
package hint_pair_pkg;
  localparam int DEF_DEPTH     = 4;
  localparam int DEF_TAG_W     = 4;
  localparam int DEF_ADDR_W    = 32;
  localparam int DEF_NUM_PIPE  = 2;
  localparam int DEF_NUM_BUF   = 6;
  localparam int DEF_NUM_FETCH = 2;

  function automatic int wrap_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/hint_pair_store.sv
module hint_pair_store #(
  parameter int DEPTH  = hint_pair_pkg::DEF_DEPTH,
  parameter int TAG_W  = hint_pair_pkg::DEF_TAG_W,
  parameter int ADDR_W = hint_pair_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [ADDR_W-1:0] push_tgt_i,
  input  logic              found_i,
  input  logic              retire_i,
  output logic              full_o,
  output logic              srch_vld_o,
  output logic [TAG_W-1:0]  srch_tag_o,
  output logic [ADDR_W-1:0] srch_tgt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  pend_q, found_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic [PTR_W-1:0]  head_q, srch_q, tail_q;
  logic [CNT_W-1:0]  cnt_q, unres_q;
  logic              retire_unres, srch_step;

  // retiring a head that never resolved also moves the search pointer
  assign retire_unres = retire_i && (unres_q == cnt_q) && (unres_q != '0);
  assign srch_step    = found_i || retire_unres;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      pend_q  <= '0;
      found_q <= '0;
      head_q  <= '0;
      srch_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      unres_q <= '0;
    end else begin
      if (push_i) begin
        pend_q[tail_q]  <= 1'b1;
        found_q[tail_q] <= 1'b0;
        tag_q[tail_q]   <= push_tag_i;
        tgt_q[tail_q]   <= push_tgt_i;
        tail_q <= PTR_W'(hint_pair_pkg::wrap_inc(int'(tail_q), DEPTH));
      end
      if (found_i) found_q[srch_q] <= 1'b1;
      if (srch_step) srch_q <= PTR_W'(hint_pair_pkg::wrap_inc(int'(srch_q), DEPTH));
      if (retire_i) begin
        pend_q[head_q] <= 1'b0;
        head_q <= PTR_W'(hint_pair_pkg::wrap_inc(int'(head_q), DEPTH));
      end
      cnt_q   <= cnt_q + CNT_W'(push_i) - CNT_W'(retire_i);
      unres_q <= unres_q + CNT_W'(push_i) - CNT_W'(srch_step);
    end
  end

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign srch_vld_o = (unres_q != '0) && pend_q[srch_q] && !found_q[srch_q];
  assign srch_tag_o = tag_q[srch_q];
  assign srch_tgt_o = tgt_q[srch_q];

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH) && unres_q <= cnt_q);
  a_r9_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && !flush_i |-> cnt_q != '0);
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> cnt_q == '0 && !srch_vld_o);
endmodule

// File: rtl/hint_pair_match.sv
module hint_pair_match #(
  parameter int N_LOC = 10,
  parameter int TAG_W = hint_pair_pkg::DEF_TAG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_vld_i,
  input  logic [TAG_W-1:0]       key_i,
  input  logic [N_LOC*TAG_W-1:0] loc_tag_i,
  input  logic [N_LOC-1:0]       loc_valid_i,
  input  logic [N_LOC-1:0]       loc_onpath_i,
  input  logic                   commit_i,
  output logic                   hit_o,
  output logic [N_LOC-1:0]       squash_o,
  output logic [N_LOC-1:0]       onpath_o
);
  localparam int IDX_W = (N_LOC > 1) ? $clog2(N_LOC) : 1;

  logic [N_LOC-1:0] hit_v;
  logic [IDX_W-1:0] win;

  for (genvar g = 0; g < N_LOC; g++) begin : g_cmp
    assign hit_v[g] = key_vld_i && loc_valid_i[g] && !loc_onpath_i[g] &&
                      (loc_tag_i[g*TAG_W +: TAG_W] == key_i);
  end

  // oldest (lowest index) hit wins
  always_comb begin
    hit_o = 1'b0;
    win   = '0;
    for (int i = N_LOC - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit_o = 1'b1;
        win   = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < N_LOC; g++) begin : g_mask
    assign squash_o[g] = commit_i && hit_o && (IDX_W'(g) > win);
    assign onpath_o[g] = commit_i && hit_o && (IDX_W'(g) <= win) && loc_valid_i[g];
  end

  a_r3_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> key_vld_i && (|(loc_valid_i & ~loc_onpath_i)));
endmodule

// File: rtl/hint_pair_tracker.sv
module hint_pair_tracker #(
  parameter int DEPTH     = hint_pair_pkg::DEF_DEPTH,
  parameter int TAG_W     = hint_pair_pkg::DEF_TAG_W,
  parameter int ADDR_W    = hint_pair_pkg::DEF_ADDR_W,
  parameter int NUM_PIPE  = hint_pair_pkg::DEF_NUM_PIPE,
  parameter int NUM_BUF   = hint_pair_pkg::DEF_NUM_BUF,
  parameter int NUM_FETCH = hint_pair_pkg::DEF_NUM_FETCH,
  localparam int N_LOC    = NUM_PIPE + NUM_BUF + NUM_FETCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   retire,
  input  logic                   hint_valid,
  output logic                   hint_ready,
  input  logic [TAG_W-1:0]       hint_tag,
  input  logic [ADDR_W-1:0]      hint_target,
  output logic                   full,
  input  logic [N_LOC*TAG_W-1:0] loc_tag,
  input  logic [N_LOC-1:0]       loc_valid,
  input  logic [N_LOC-1:0]       loc_onpath,
  output logic                   redir_valid,
  input  logic                   redir_ready,
  output logic [ADDR_W-1:0]      redir_target,
  output logic [N_LOC-1:0]       squash_mask,
  output logic [N_LOC-1:0]       onpath_mask
);
  logic             srch_vld, hit, commit;
  logic [TAG_W-1:0] srch_tag;

  assign hint_ready  = !full && !flush;
  assign redir_valid = srch_vld && hit && !flush;
  assign commit      = redir_valid && redir_ready;

  hint_pair_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .push_i     (hint_valid && hint_ready),
    .push_tag_i (hint_tag),
    .push_tgt_i (hint_target),
    .found_i    (commit),
    .retire_i   (retire),
    .full_o     (full),
    .srch_vld_o (srch_vld),
    .srch_tag_o (srch_tag),
    .srch_tgt_o (redir_target)
  );

  hint_pair_match #(.N_LOC(N_LOC), .TAG_W(TAG_W)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_vld_i    (srch_vld),
    .key_i        (srch_tag),
    .loc_tag_i    (loc_tag),
    .loc_valid_i  (loc_valid),
    .loc_onpath_i (loc_onpath),
    .commit_i     (commit),
    .hit_o        (hit),
    .squash_o     (squash_mask),
    .onpath_o     (onpath_mask)
  );

  a_r11_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !redir_ready && !retire |=> !redir_valid || $stable(redir_target));
  a_r5_masks_need_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && redir_ready) |-> squash_mask == '0 && onpath_mask == '0);
endmodule

// File: tb/hint_pair_tracker_test.sv
module hint_pair_tracker_test;
  localparam int TAG_W = 4;
  localparam int ADDR_W = 32;
  localparam int NL = 10;

  logic clk = 0, rst_n = 0, flush = 0, retire = 0;
  logic hint_valid = 0, redir_ready = 1;
  logic hint_ready, full, redir_valid;
  logic [TAG_W-1:0] hint_tag = '0;
  logic [ADDR_W-1:0] hint_target = '0, redir_target;
  logic [NL*TAG_W-1:0] loc_tag;
  logic [NL-1:0] loc_valid, loc_onpath, squash_mask, onpath_mask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hint_pair_tracker uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .retire(retire),
    .hint_valid(hint_valid), .hint_ready(hint_ready), .hint_tag(hint_tag),
    .hint_target(hint_target), .full(full), .loc_tag(loc_tag),
    .loc_valid(loc_valid), .loc_onpath(loc_onpath), .redir_valid(redir_valid),
    .redir_ready(redir_ready), .redir_target(redir_target),
    .squash_mask(squash_mask), .onpath_mask(onpath_mask));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bg();
    for (int i = 0; i < NL; i++) loc_tag[i*TAG_W +: TAG_W] = 4'hF;
    loc_valid = '1;
    loc_onpath = '0;
  endtask

  task automatic put(input int i, input logic [TAG_W-1:0] t);
    loc_tag[i*TAG_W +: TAG_W] = t;
  endtask

  task automatic push(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    hint_valid = 1; hint_tag = t; hint_target = a;
    @(negedge clk);
    hint_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    #2;
    chk("R1 ready", hint_ready, 1);
    chk("R1 full", full, 0);
    chk("R1 redir", redir_valid, 0);
    chk("R1 masks", {squash_mask, onpath_mask}, 0);
  endtask

  task automatic t_qualify();
    push(4'h5, 32'hA000);
    @(negedge clk);
    put(3, 4'h5); loc_onpath[3] = 1;
    put(4, 4'h5); loc_valid[4] = 0;
    #2 chk("R3 onpath/invalid excluded", redir_valid, 0);
    @(negedge clk);
    #2 chk("R7 still waiting", redir_valid, 0);
    @(negedge clk);
    put(7, 4'h5);
    #2;
    chk("R7 redirect on hit", redir_valid, 1);
    chk("R6 target", redir_target, 32'hA000);
    chk("R5 squash", squash_mask, 10'h300);
    chk("R5 onpath", onpath_mask, 10'h0EF);
    @(negedge clk);
    #2 chk("R6 single redirect", redir_valid, 0);
    bg(); do_flush();
  endtask

  task automatic t_oldest();
    push(4'h2, 32'hB000);
    @(negedge clk);
    put(2, 4'h2); put(6, 4'h2); put(9, 4'h2); loc_valid[0] = 0;
    #2;
    chk("R4 redirect", redir_valid, 1);
    chk("R4 oldest squash", squash_mask, 10'h3F8);
    chk("R5 onpath older valid", onpath_mask, 10'h006);
    bg(); do_flush();
  endtask

  task automatic t_order();
    push(4'h1, 32'h1111);
    push(4'h3, 32'h3333);
    @(negedge clk);
    put(5, 4'h3);
    #2 chk("R8 younger waits", redir_valid, 0);
    @(negedge clk);
    put(1, 4'h1);
    #2;
    chk("R8 first target", redir_target, 32'h1111);
    chk("R5 squash first", squash_mask, 10'h3FC);
    chk("R5 onpath first", onpath_mask, 10'h003);
    @(negedge clk);
    #2;
    chk("R8 second redir", redir_valid, 1);
    chk("R8 second target", redir_target, 32'h3333);
    chk("R5 squash second", squash_mask, 10'h3C0);
    @(negedge clk);
    #2 chk("R6 no third", redir_valid, 0);
    retire = 1;
    @(negedge clk); @(negedge clk);
    retire = 0;
    bg(); do_flush();
  endtask

  task automatic t_backpressure();
    push(4'h6, 32'h66);
    @(negedge clk);
    redir_ready = 0; put(3, 4'h6);
    #2;
    chk("R11 valid held", redir_valid, 1);
    chk("R11 masks zero", {squash_mask, onpath_mask}, 0);
    @(negedge clk);
    #2;
    chk("R11 still offered", redir_valid, 1);
    chk("R11 target", redir_target, 32'h66);
    redir_ready = 1;
    #1;
    chk("R5 squash accepted", squash_mask, 10'h3F0);
    chk("R5 onpath accepted", onpath_mask, 10'h00F);
    @(negedge clk);
    #2 chk("R6 consumed", redir_valid, 0);
    bg(); do_flush();
  endtask

  task automatic t_full();
    for (int k = 1; k <= 4; k++) push(TAG_W'(k), ADDR_W'(k * 256));
    #2;
    chk("R2 full", full, 1);
    chk("R2 not ready", hint_ready, 0);
    push(4'h7, 32'h7777);
    retire = 1;
    @(negedge clk);
    retire = 0;
    #2;
    chk("R9 full cleared", full, 0);
    chk("R9 ready", hint_ready, 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      bg(); put(0, TAG_W'(1)); put(1, TAG_W'(k));
      #2;
      chk("R9 head gone, in order", redir_target, ADDR_W'(k * 256));
      chk("R9 redir", redir_valid, 1);
    end
    @(negedge clk);
    bg(); put(0, 4'h7);
    #2 chk("R2 discarded hint", redir_valid, 0);
    bg(); do_flush();
  endtask

  task automatic t_flush();
    push(4'h5, 32'h55);
    @(negedge clk);
    put(2, 4'h5); flush = 1;
    #2;
    chk("R10 redir blocked", redir_valid, 0);
    chk("R10 ready low", hint_ready, 0);
    @(negedge clk);
    flush = 0;
    #2;
    chk("R10 emptied", redir_valid, 0);
    chk("R10 not full", full, 0);
    bg();
  endtask

  initial begin
    bg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_qualify();
    t_oldest();
    t_order();
    t_backpressure();
    t_full();
    t_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule